// File: doc/BRIEF.md
# OSD-over-video pixel blender

This block overlays one of two on-screen-display (OSD) windows onto a video stream, one pixel at a time. Each incoming beat carries a video pixel in YCbCr 4:4:4 form together with a raw OSD bitmap index and a tag naming the OSD window it belongs to.

The raw index is first masked to the window's bit depth of 1, 2, 4 or 8 bits. Indices narrower than 8 bits are then remapped through that window's 16-entry palette map. The resulting 8-bit colour index is looked up either in a computed greyscale ROM table or in a writable 256-entry RAM table. The OSD colour is then mixed with the video pixel in eighths, according to a 3-bit blend code. An optional colour key makes matching OSD pixels transparent.

Configuration arrives through a single write port, which loads the window controls, the palette maps and the colour RAM. Pixels move through a fixed two-stage pipeline with a valid/ready handshake at both ends.

Top module: `osd_vid_mixer`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high. Every window control is zero (blend code 0), every palette map entry holds its own position (identity), and every colour RAM entry is zero.
- R2: A pixel accepted on edge k (with `in_valid` and `in_ready` both high) appears on the outputs with `out_valid` high after edge k+1, provided the output is not stalled.
- R3: While `out_valid` is high and `out_ready` is low, the outputs hold their values, `out_valid` stays high and `in_ready` is low.
- R4: Each output component equals (O*W + V*(8-W) + 4) >> 3, where O is the OSD colour component and V is the video component. W is the blend code n for codes 0 to 6, and W is 8 for code 7.
- R5: Blend code 7 outputs the OSD colour exactly.
- R6: Blend code 0 outputs the video pixel unchanged.
- R7: When the window's key enable (control bit 3) is set, an OSD pixel whose masked raw index equals the key byte (control bits 15:8) is treated as fully transparent, and the video pixel is output.
- R8: The depth field (control bits 6:5) masks the raw index to its low 1, 2 or 4 bits for codes 0, 1 and 2. For these depths, the masked value selects a palette map entry, and that entry's value is the colour index.
- R9: With depth code 3 (8 bits), the raw index is used directly as the colour index, and the palette map is not used.
- R10: The table-select bit (control bit 4) picks the RAM entry when it is 1. When it is 0, it picks the ROM colour, which is Y equal to the index and Cb = Cr = 128.
- R11: Each window's blend code, key, depth, table select and palette map apply only to pixels tagged with that window.
- R12: Write port: `cfg_sel` 0 loads window `cfg_win` control from `cfg_data[15:0]` (bits 2:0 hold the blend code). `cfg_sel` 1 loads palette entry `cfg_idx[3:0]` of window `cfg_win` from `cfg_data[7:0]`. `cfg_sel` 2 loads colour RAM entry `cfg_idx` with {Y,Cb,Cr} from `cfg_data`. `cfg_sel` 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 control, 1 palette, 2 colour RAM, 3 none |
| cfg_win | input | 1 | Window addressed by control and palette writes |
| cfg_idx | input | 8 | Palette entry (low 4 bits) or colour RAM entry |
| cfg_data | input | 24 | Write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_win | input | 1 | OSD window of the input pixel |
| in_idx | input | 8 | Raw OSD bitmap index |
| in_y | input | 8 | Video Y |
| in_cb | input | 8 | Video Cb |
| in_cr | input | 8 | Video Cr |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_y | output | 8 | Mixed Y |
| out_cb | output | 8 | Mixed Cb |
| out_cr | output | 8 | Mixed Cr |

## Verification
A pixel presented before edge k is due on the outputs one edge later, after edge k+1. The bench therefore checks `out_valid` low at the falling edge after acceptance and high, with the mixed value, at the falling edge after the next rising edge. During a stall the result stays put for as long as `out_ready` is low, and it is compared again on every stalled cycle. Configuration writes take effect on the edge that samples them, so each write completes before the pixel that depends on it is driven.

// File: rtl/osd_mix_pkg.sv
package osd_mix_pkg;

    localparam int IDX_W  = 8;
    localparam int TBL_N  = 1 << IDX_W;
    localparam int PAL_N  = 16;
    localparam int PAL_W  = $clog2(PAL_N);
    localparam int CTRL_W = 16;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_PAL  = 2'd1,
        SEL_CLUT = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [7:0] key;
        logic       spare;
        logic [1:0] depth;
        logic       use_ram;
        logic       key_en;
        logic [2:0] blend;
    } win_ctrl_t;

    function automatic logic [3:0] weight_of(input logic [2:0] code);
        return (code == 3'd7) ? 4'd8 : {1'b0, code};
    endfunction

    function automatic logic [IDX_W-1:0] depth_mask(input logic [1:0] depth);
        case (depth)
            2'd0:    return 8'h01;
            2'd1:    return 8'h03;
            2'd2:    return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/osd_mix_cfg.sv
module osd_mix_cfg
    import osd_mix_pkg::*;
#(
    parameter int CW   = 8,
    parameter int NWIN = 2,
    parameter int WW   = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [WW-1:0]         wr_win,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [3*CW-1:0]       wr_data,
    input  logic [WW-1:0]         rd_win,
    output win_ctrl_t             rd_ctrl,
    input  logic [PAL_W-1:0]      pal_idx,
    output logic [IDX_W-1:0]      pal_val,
    input  logic [IDX_W-1:0]      tbl_idx,
    input  logic                  tbl_ram,
    output logic [3*CW-1:0]       tbl_val
);

    localparam logic [CW-1:0] HALF = CW'(1) << (CW - 1);

    win_ctrl_t        ctrl_arr [NWIN];
    logic [IDX_W-1:0] pal_rd   [NWIN];
    logic [3*CW-1:0]  ram_q    [TBL_N];
    logic [3*CW-1:0]  rom_val;

    for (genvar gw = 0; gw < NWIN; gw++) begin : g_win
        win_ctrl_t        ctrl_d, ctrl_q;
        logic [IDX_W-1:0] pal_q [PAL_N];
        logic             hit_win;

        assign hit_win = wr_en && (wr_win == WW'(gw));

        always_comb begin
            ctrl_d = ctrl_q;
            if (hit_win && wr_sel == SEL_CTRL)
                ctrl_d = win_ctrl_t'(wr_data[CTRL_W-1:0]);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ctrl_q <= '0;
            else        ctrl_q <= ctrl_d;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < PAL_N; i++) pal_q[i] <= IDX_W'(i);
            end else if (hit_win && wr_sel == SEL_PAL) begin
                pal_q[wr_idx[PAL_W-1:0]] <= wr_data[IDX_W-1:0];
            end
        end

        assign ctrl_arr[gw] = ctrl_q;
        assign pal_rd[gw]   = pal_q[pal_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TBL_N; i++) ram_q[i] <= '0;
        end else if (wr_en && wr_sel == SEL_CLUT) begin
            ram_q[wr_idx] <= wr_data;
        end
    end

    assign rom_val = {CW'(tbl_idx) << (CW - IDX_W), HALF, HALF};
    assign rd_ctrl = ctrl_arr[rd_win];
    assign pal_val = pal_rd[rd_win];
    assign tbl_val = tbl_ram ? ram_q[tbl_idx] : rom_val;

endmodule

// File: rtl/osd_mix_blend.sv
module osd_mix_blend #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] osd_c,
    input  logic [CW-1:0] vid_c,
    input  logic [3:0]    wgt,
    output logic [CW-1:0] mix_c
);

    localparam int SW = CW + 4;

    logic [SW-1:0] sum;
    logic [CW-1:0] lo, hi;

    always_comb begin
        sum   = SW'(osd_c) * SW'(wgt) + SW'(vid_c) * SW'(4'd8 - wgt) + SW'(4);
        mix_c = sum[CW+2:3];
        lo    = (osd_c < vid_c) ? osd_c : vid_c;
        hi    = (osd_c < vid_c) ? vid_c : osd_c;
    end

    always_comb begin
        if (wgt == 4'd8) AST_OPAQUE_EXACT: assert (mix_c == osd_c); // R5
        if (wgt == 4'd0) AST_TRANSPARENT_VIDEO: assert (mix_c == vid_c); // R6
        AST_MIX_BOUNDED: assert (mix_c >= lo && mix_c <= hi); // R4
    end

endmodule

// File: rtl/osd_vid_mixer.sv
module osd_vid_mixer
    import osd_mix_pkg::*;
#(
    parameter int CW   = 8,
    parameter int NWIN = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cfg_we,
    input  logic [1:0]                             cfg_sel,
    input  logic [((NWIN > 1) ? $clog2(NWIN) : 1)-1:0] cfg_win,
    input  logic [7:0]                             cfg_idx,
    input  logic [3*CW-1:0]                        cfg_data,
    input  logic                                   in_valid,
    output logic                                   in_ready,
    input  logic [((NWIN > 1) ? $clog2(NWIN) : 1)-1:0] in_win,
    input  logic [7:0]                             in_idx,
    input  logic [CW-1:0]                          in_y,
    input  logic [CW-1:0]                          in_cb,
    input  logic [CW-1:0]                          in_cr,
    output logic                                   out_valid,
    input  logic                                   out_ready,
    output logic [CW-1:0]                          out_y,
    output logic [CW-1:0]                          out_cb,
    output logic [CW-1:0]                          out_cr
);

    localparam int WW = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam int PW = 3 * CW;

    typedef struct packed {
        logic             s1_valid;
        logic [IDX_W-1:0] s1_ci;
        logic [3:0]       s1_w;
        logic             s1_ram;
        logic [PW-1:0]    s1_vid;
        logic             s2_valid;
        logic [PW-1:0]    s2_pix;
    } pipe_t;

    pipe_t            q, d;
    win_ctrl_t        cur;
    logic [IDX_W-1:0] masked, pal_val, ci_d;
    logic             key_hit, adv;
    logic [PW-1:0]    osd_col, mix;

    osd_mix_cfg #(.CW(CW), .NWIN(NWIN), .WW(WW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_win  (cfg_win),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_data),
        .rd_win  (in_win),
        .rd_ctrl (cur),
        .pal_idx (masked[PAL_W-1:0]),
        .pal_val (pal_val),
        .tbl_idx (q.s1_ci),
        .tbl_ram (q.s1_ram),
        .tbl_val (osd_col)
    );

    for (genvar gc = 0; gc < 3; gc++) begin : g_comp
        osd_mix_blend #(.CW(CW)) u_blend (
            .osd_c (osd_col[gc*CW +: CW]),
            .vid_c (q.s1_vid[gc*CW +: CW]),
            .wgt   (q.s1_w),
            .mix_c (mix[gc*CW +: CW])
        );
    end

    always_comb begin
        adv     = !q.s2_valid || out_ready;
        masked  = in_idx & depth_mask(cur.depth);
        key_hit = cur.key_en && (masked == cur.key);
        ci_d    = (cur.depth == 2'd3) ? in_idx : pal_val;

        d = q;
        if (adv) begin
            d.s1_valid = in_valid;
            d.s1_ci    = ci_d;
            d.s1_w     = key_hit ? 4'd0 : weight_of(cur.blend);
            d.s1_ram   = cur.use_ram;
            d.s1_vid   = {in_y, in_cb, in_cr};
            d.s2_valid = q.s1_valid;
            d.s2_pix   = mix;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready  = adv;
    assign out_valid = q.s2_valid;
    assign out_y     = q.s2_pix[3*CW-1:2*CW];
    assign out_cb    = q.s2_pix[2*CW-1:CW];
    assign out_cr    = q.s2_pix[CW-1:0];

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_y) && $stable(out_cb) && $stable(out_cr)); // R3
    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> q.s1_valid); // R2
    AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        q.s1_valid && in_ready |=> out_valid); // R2

endmodule

// File: tb/sim_osd_vid_mixer.sv
module sim_osd_vid_mixer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [0:0]  cfg_win = '0;
    logic [7:0]  cfg_idx = '0;
    logic [23:0] cfg_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [0:0]  in_win = '0;
    logic [7:0]  in_idx = '0;
    logic [7:0]  in_y = '0, in_cb = '0, in_cr = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_y, out_cb, out_cr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [23:0] sh_ram [256];
    logic [7:0]  sh_pal [2][16];
    logic [15:0] sh_ctrl [2];

    always #2 clk = ~clk;

    osd_vid_mixer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_win(cfg_win), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_win(in_win),
        .in_idx(in_idx), .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
    );

    // ctrl[63:48] win[40] idx[39:32] vid{Y,Cb,Cr}[31:8]
    localparam int NV = 13;
    localparam logic [63:0] VEC [NV] = '{
        64'h0054_00_05_14_50_64_00,
        64'h0057_00_15_C8_10_F0_00,
        64'h0050_00_05_33_44_55_00,
        64'h0558_00_25_11_22_33_00,
        64'h0558_00_06_FF_FF_FF_00,
        64'h0067_01_9A_00_80_40_00,
        64'h0077_01_02_AA_BB_CC_00,
        64'h0016_01_FF_01_02_03_00,
        64'h0022_01_06_F0_0F_80_00,
        64'h0015_00_03_40_40_40_00,
        64'h0041_00_03_FE_01_7F_00,
        64'h9A6F_01_9A_12_34_56_00,
        64'h9A6F_01_9B_12_34_56_00
    };
    string TAG [NV] = '{"R4 R10", "R5 R8", "R6", "R7 R8", "R7 R4", "R9 R10 R5", "R9",
                        "R8 R4", "R8 R10", "R8 R4", "R4 R10", "R7 R9", "R7 R10"};

    function automatic logic [23:0] model(input logic w, input logic [7:0] raw,
                                          input logic [23:0] vid);
        logic [15:0] c;
        logic [7:0]  m, ci;
        logic [23:0] col, res;
        int          wt, o, v;
        c = sh_ctrl[w];
        case (c[6:5])
            2'd0: m = raw & 8'h01;
            2'd1: m = raw & 8'h03;
            2'd2: m = raw & 8'h0F;
            default: m = raw;
        endcase
        ci  = (c[6:5] == 2'd3) ? raw : sh_pal[w][m[3:0]];
        col = c[4] ? sh_ram[ci] : {ci, 8'd128, 8'd128};
        if (c[3] && m == c[15:8]) wt = 0;
        else if (c[2:0] == 3'd7)  wt = 8;
        else                      wt = int'(c[2:0]);
        for (int k = 0; k < 3; k++) begin
            o = int'(col[k*8 +: 8]);
            v = int'(vid[k*8 +: 8]);
            res[k*8 +: 8] = 8'((o * wt + v * (8 - wt) + 4) >> 3);
        end
        return res;
    endfunction

    task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic w, input logic [7:0] idx,
                      input logic [23:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_win = w; cfg_idx = idx; cfg_data = data;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            2'd0: sh_ctrl[w] = data[15:0];
            2'd1: sh_pal[w][idx[3:0]] = data[7:0];
            2'd2: sh_ram[idx] = data;
            default: ;
        endcase
    endtask

    // Drives one pixel with out_ready high; returns the output two edges later.
    task automatic send(input logic w, input logic [7:0] idx, input logic [23:0] vid,
                        input string req, output logic [23:0] got);
        @(negedge clk);
        in_valid = 1'b1; in_win = w; in_idx = idx; {in_y, in_cb, in_cr} = vid;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R2 not yet valid"}, {23'd0, out_valid}, 24'd0);
        @(posedge clk);
        @(negedge clk);
        check({req, " R2 valid"}, {23'd0, out_valid}, 24'd1);
        got = {out_y, out_cb, out_cr};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] got, exp, snap;
        for (int i = 0; i < 256; i++) sh_ram[i] = '0;
        for (int w = 0; w < 2; w++) begin
            sh_ctrl[w] = '0;
            for (int i = 0; i < 16; i++) sh_pal[w][i] = 8'(i);
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 out_valid in reset", {23'd0, out_valid}, 24'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", {23'd0, out_valid}, 24'd0);
        check("R1 in_ready after reset", {23'd0, in_ready}, 24'd1);

        // R1: reset state means blend 0, so video passes through
        send(1'b0, 8'h05, 24'h123456, "R1", got);
        check("R1 reset controls transparent", got, 24'h123456);

        // R12 setup writes
        wr(2'd2, 1'b0, 8'd200, 24'h6432DC);
        wr(2'd2, 1'b0, 8'd7,   24'h1EF010);
        wr(2'd2, 1'b0, 8'd255, 24'hFF00FF);
        wr(2'd1, 1'b0, 8'd5, 24'd200);
        wr(2'd1, 1'b0, 8'd3, 24'd10);
        wr(2'd1, 1'b0, 8'd1, 24'd7);
        wr(2'd1, 1'b1, 8'd1, 24'd255);
        wr(2'd1, 1'b1, 8'd2, 24'd200);

        for (int v = 0; v < NV; v++) begin
            wr(2'd0, VEC[v][40], 8'd0, {8'd0, VEC[v][63:48]});
            send(VEC[v][40], VEC[v][39:32], VEC[v][31:8], TAG[v], got);
            exp = model(VEC[v][40], VEC[v][39:32], VEC[v][31:8]);
            check(TAG[v], got, exp);
        end

        // R11: window 0 transparent, window 1 opaque ROM 8-bit
        wr(2'd0, 1'b0, 8'd0, 24'h000050);
        wr(2'd0, 1'b1, 8'd0, 24'h000067);
        send(1'b1, 8'h40, 24'h010203, "R11", got);
        check("R11 win1 own settings", got, 24'h408080);
        send(1'b0, 8'h05, 24'h0A0B0C, "R11", got);
        check("R11 win0 own settings", got, 24'h0A0B0C);

        // R12: select 3 changes nothing
        wr(2'd0, 1'b0, 8'd0, 24'h000057);
        wr(2'd3, 1'b0, 8'd5, 24'h000000);
        wr(2'd3, 1'b0, 8'd200, 24'h000000);
        send(1'b0, 8'h05, 24'h777777, "R12", got);
        check("R12 select 3 ignored", got, 24'h6432DC);

        // R3: stall with out_ready low
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_win = 1'b0; in_idx = 8'h05; {in_y, in_cb, in_cr} = 24'h000000;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        snap = {out_y, out_cb, out_cr};
        check("R3 stalled value", snap, model(1'b0, 8'h05, 24'h000000));
        for (int c = 0; c < 3; c++) begin
            @(posedge clk);
            @(negedge clk);
            check("R3 valid held", {23'd0, out_valid}, 24'd1);
            check("R3 in_ready low", {23'd0, in_ready}, 24'd0);
            check("R3 data held", {out_y, out_cb, out_cr}, snap);
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R3 drained", {23'd0, out_valid}, 24'd0);
        check("R3 ready again", {23'd0, in_ready}, 24'd1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule